// File: doc/BRIEF.md
# Paged 48-Line Parallel I/O with Edge Interrupts

This peripheral gives a host 48 general-purpose lines, grouped as six 8-bit ports, through an 8-bit register window at addresses 0 to 10. Every line is open-drain. An output latch bit of 0 pulls the line low. A bit of 1 releases the line, and the line can then be read as an input. Reads of a port's data address return the synchronized pin levels, not the latch.

The lines of the three lowest ports can latch edge events. Each of these 24 lines has a polarity bit, an enable bit and a latched identification bit. All three kinds of register appear at addresses 8 to 10, one address per port, and a page field in the control register at address 7 picks which kind is visible there. Address 6 summarizes which of the three ports holds a latched event, and `irq_o` is high while any event is latched. Software acknowledges a line by writing its enable bit to 0 and then back to 1.

Top module: `pio48_paged`

## Requirements
- R1: After reset, every `latch_o` bit is 1, address 7 reads 0x00, polarity, enable and ID bits are 0, address 6 reads 0x00 and `irq_o` is low.
- R2: A write to address p (0..5) of an unlocked port loads `latch_o[8p+7:8p]`. A read of address p returns `pin_i[8p+7:8p]` as sampled through two register stages.
- R3: Address 7 holds the page in bits 7:6 (0 none, 1 polarity, 2 enable, 3 ID) and the lock bits of ports 5..0 in bits 5:0. It reads back as written.
- R4: A data write to a port whose lock bit is 1 leaves its latch unchanged. Reads of that port still return pin levels.
- R5: On page 1, address 8+k (k = 0..2) reads and writes the polarity byte of port k. A 1 selects rising-edge detection and a 0 selects falling-edge detection.
- R6: On page 2, address 8+k reads and writes the enable byte of port k.
- R7: An edge of the selected polarity on a synchronized line whose enable bit is 1 sets that line's ID bit. The ID bit holds until it is cleared. On page 3, address 8+k reads the ID byte of port k.
- R8: Edges on a line whose enable bit is 0, and edges opposite to the selected polarity, set no ID bit.
- R9: One clock after a line's enable bit is 0, its ID bit is 0. Writing the enable byte with the bit cleared and then set acknowledges the event.
- R10: Address 6 bit k is 1 when port k has any ID bit set, and bits 7:3 read 0. `irq_o` is high exactly when any of bits 2:0 is 1.
- R11: Pin activity on ports 3..5 never sets a pending bit.
- R12: On page 0, addresses 8..10 read 0x00. Writes to addresses 8..10 on pages 0 and 3, and writes to address 6, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register address |
| wr_i | input | 1 | Write strobe, one clock per write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| pin_i | input | 48 | Sensed line levels |
| latch_o | output | 48 | Output latches, 0 pulls the line low |
| irq_o | output | 1 | Interrupt, high while any event is latched |

## Verification
A wrong polarity or enable bit, or a missed edge, shows up on `irq_o` and address 6 three clock edges after the pin changes. The synchronizer accounts for two of those edges and the ID latch for the third. An ID bit that the acknowledge does not clear keeps `irq_o` high after the second enable write. A page or lock field that is wrong shows up on the next read of addresses 7 to 10, or as a change on `latch_o` one edge after a write that should have been ignored.

// File: rtl/pio48_pkg.sv
package pio48_pkg;
  timeunit 1ns; timeprecision 1ps;
  localparam int PIO_PORT_W   = 8;
  localparam int PIO_N_PORTS  = 6;
  localparam int PIO_N_IRQ    = 3;
  localparam int PIO_ADDR_W   = 4;
  localparam int OFF_PEND     = 6;
  localparam int OFF_CTRL     = 7;
  localparam int OFF_PAGED    = 8;

  typedef enum logic [1:0] {
    PG_NONE = 2'd0,
    PG_POL  = 2'd1,
    PG_EN   = 2'd2,
    PG_ID   = 2'd3
  } page_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  timeunit 1ns; timeprecision 1ps;
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pio_irq_port.sv
module pio_irq_port #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] id_o
);
  timeunit 1ns; timeprecision 1ps;
  logic [W-1:0] prev_q, id_q, hit;

  assign hit = (pol_i & lvl_i & ~prev_q) | (~pol_i & ~lvl_i & prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      id_q   <= '0;
    end else begin
      prev_q <= lvl_i;
      id_q   <= en_i & (id_q | hit);  // enable low doubles as clear
    end
  end

  assign id_o = id_q;

  a_r7_edge_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(hit & en_i)) |=> ((id_q & $past(hit & en_i)) == $past(hit & en_i)));
  a_r8_new_only_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((id_q & ~$past(id_q) & ~$past(en_i)) == '0));
  a_r9_clear_on_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((id_q & ~$past(en_i)) == '0));
endmodule

// File: rtl/pio48_paged.sv
module pio48_paged
  import pio48_pkg::*;
#(
  parameter int PORT_W  = PIO_PORT_W,
  parameter int N_PORTS = PIO_N_PORTS,
  parameter int N_IRQ   = PIO_N_IRQ,
  parameter int ADDR_W  = PIO_ADDR_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      wr_i,
  input  logic [PORT_W-1:0]         wdata_i,
  output logic [PORT_W-1:0]         rdata_o,
  input  logic [PORT_W*N_PORTS-1:0] pin_i,
  output logic [PORT_W*N_PORTS-1:0] latch_o,
  output logic                      irq_o
);
  timeunit 1ns; timeprecision 1ps;
  localparam int N_LINES = PORT_W * N_PORTS;

  logic [N_LINES-1:0] pin_s;
  logic [PORT_W-1:0]  lat_q [N_PORTS];
  logic [PORT_W-1:0]  ctrl_q;
  logic [PORT_W-1:0]  pol_q [N_IRQ];
  logic [PORT_W-1:0]  en_q  [N_IRQ];
  logic [PORT_W-1:0]  id_w  [N_IRQ];
  logic [N_IRQ-1:0]   pend;
  logic [N_PORTS-1:0] lock;
  page_e              page;

  assign lock = ctrl_q[N_PORTS-1:0];
  assign page = page_e'(ctrl_q[PORT_W-1 -: 2]);

  pio_sync #(.W(N_LINES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr_i && addr_i == ADDR_W'(OFF_CTRL)) ctrl_q <= wdata_i;
  end

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lat_q[p] <= '1;
      else if (wr_i && addr_i == ADDR_W'(p) && !lock[p]) lat_q[p] <= wdata_i;
    end
    assign latch_o[p*PORT_W +: PORT_W] = lat_q[p];

    a_r4_locked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i == ADDR_W'(p) && lock[p]) |=> $stable(lat_q[p]));
  end

  for (genvar k = 0; k < N_IRQ; k++) begin : g_irq
    logic sel;
    assign sel = wr_i && addr_i == ADDR_W'(OFF_PAGED + k);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pol_q[k] <= '0;
        en_q[k]  <= '0;
      end else begin
        if (sel && page == PG_POL) pol_q[k] <= wdata_i;
        if (sel && page == PG_EN)  en_q[k]  <= wdata_i;
      end
    end

    pio_irq_port #(.W(PORT_W)) u_irq (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_i (pin_s[k*PORT_W +: PORT_W]),
      .pol_i (pol_q[k]),
      .en_i  (en_q[k]),
      .id_o  (id_w[k])
    );
    assign pend[k] = |id_w[k];

    a_r5_pol_page_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel && page != PG_POL) |=> $stable(pol_q[k]));
    a_r6_en_page_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel && page != PG_EN) |=> $stable(en_q[k]));
  end

  assign irq_o = |pend;

  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < N_PORTS; p++)
      if (addr_i == ADDR_W'(p)) rdata_o = pin_s[p*PORT_W +: PORT_W];
    if (addr_i == ADDR_W'(OFF_PEND)) rdata_o = PORT_W'(pend);
    if (addr_i == ADDR_W'(OFF_CTRL)) rdata_o = ctrl_q;
    for (int k = 0; k < N_IRQ; k++)
      if (addr_i == ADDR_W'(OFF_PAGED + k)) begin
        unique case (page)
          PG_POL:  rdata_o = pol_q[k];
          PG_EN:   rdata_o = en_q[k];
          PG_ID:   rdata_o = id_w[k];
          default: rdata_o = '0;
        endcase
      end
  end

  a_r10_irq_follows_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (pend != '0));
endmodule

// File: tb/tb_pio48_paged.sv
module tb_pio48_paged;
  timeunit 1ns; timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [47:0] ext = '1;
  logic [47:0] pin;
  logic [47:0] latch;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  // bench-side model
  logic [47:0] m_lat = '1;
  logic [47:0] m_pin = '1;
  logic [5:0]  m_lock = '0;
  logic [1:0]  m_page = '0;
  logic [23:0] m_pol = '0;
  logic [23:0] m_en = '0;
  logic [23:0] m_id = '0;

  assign pin = latch & ext;  // open-drain wired level

  always #4 clk = ~clk;

  pio48_paged dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .addr_i (addr),
    .wr_i   (wr),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .pin_i  (pin),
    .latch_o(latch),
    .irq_o  (irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input int a);
    logic [7:0] r;
    r = 8'h00;
    if (a < 6) r = m_pin[a*8 +: 8];
    else if (a == 6) r = {5'b0, |m_id[23:16], |m_id[15:8], |m_id[7:0]};
    else if (a == 7) r = {m_page, m_lock};
    else if (a <= 10) begin
      case (m_page)
        2'd1: r = m_pol[(a-8)*8 +: 8];
        2'd2: r = m_en[(a-8)*8 +: 8];
        2'd3: r = m_id[(a-8)*8 +: 8];
        default: r = 8'h00;
      endcase
    end
    return r;
  endfunction

  function automatic string tag_of(input int a);
    if (a < 6) return "R2 data read";
    if (a == 6) return "R10 pending";
    if (a == 7) return "R3 ctrl";
    case (m_page)
      2'd1: return "R5 polarity";
      2'd2: return "R6 enable";
      2'd3: return "R7 id";
      default: return "R12 page0";
    endcase
  endfunction

  // wait for sync + latch, then advance the model's edge view
  task automatic settle();
    logic [47:0] nw;
    logic [23:0] hit;
    repeat (5) @(negedge clk);
    nw  = m_lat & ext;
    hit = (m_pol & nw[23:0] & ~m_pin[23:0]) | (~m_pol & ~nw[23:0] & m_pin[23:0]);
    m_id  = m_id | (hit & m_en);
    m_pin = nw;
  endtask

  task automatic wr_reg(input int a, input logic [7:0] d);
    @(negedge clk);
    addr = 4'(a); wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    if (a < 6) begin
      if (!m_lock[a]) m_lat[a*8 +: 8] = d;
    end else if (a == 7) begin
      m_page = d[7:6]; m_lock = d[5:0];
    end else if (a >= 8 && a <= 10) begin
      if (m_page == 2'd1) m_pol[(a-8)*8 +: 8] = d;
      if (m_page == 2'd2) begin
        m_en[(a-8)*8 +: 8] = d;
        m_id = m_id & m_en;
      end
    end
    settle();
  endtask

  task automatic set_ext(input logic [47:0] v);
    @(negedge clk);
    ext = v;
    settle();
  endtask

  task automatic check_all();
    for (int a = 0; a <= 10; a++) begin
      @(negedge clk);
      addr = 4'(a);
      #1 chk(tag_of(a), 64'(rdata), 64'(exp_rd(a)));
    end
    chk("R10 irq_o", 64'(irq), 64'(|m_id));
    chk("R2 latch_o", 64'(latch), 64'(m_lat));
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R1 reset state
    chk("R1 latch reset", 64'(latch), 64'hFFFF_FFFF_FFFF);
    chk("R1 irq reset", 64'(irq), 64'd0);
    check_all();

    // R7/R8: line 0 rising, enabled; line 1 falling, disabled
    wr_reg(7, 8'h80); wr_reg(8, 8'h01);
    wr_reg(7, 8'h40); wr_reg(8, 8'h01);
    set_ext(ext & ~48'h1);
    chk("R8 opposite edge ignored", 64'(irq), 64'd0);
    set_ext(ext | 48'h1);
    chk("R7 rising edge irq", 64'(irq), 64'd1);
    set_ext(ext & ~48'h2);
    wr_reg(7, 8'hC0);
    @(negedge clk); addr = 4'd8;
    #1 chk("R8 disabled line not latched", 64'(rdata), 64'h01);
    check_all();

    // R9 acknowledge by enable drop and restore
    wr_reg(7, 8'h80); wr_reg(8, 8'h00);
    chk("R9 cleared after enable 0", 64'(irq), 64'd0);
    wr_reg(8, 8'h01);
    chk("R9 stays clear after restore", 64'(irq), 64'd0);
    check_all();

    // R4 locked port keeps latch
    wr_reg(7, 8'h04); wr_reg(2, 8'h00);
    chk("R4 locked latch held", 64'(latch[23:16]), 64'hFF);
    @(negedge clk); addr = 4'd2;
    #1 chk("R4 locked read works", 64'(rdata), 64'(pin[23:16]));
    wr_reg(7, 8'h00);

    // R12 writes on page 0 / page 3 / pending address ignored
    wr_reg(9, 8'hFF); wr_reg(6, 8'hFF);
    wr_reg(7, 8'hC0); wr_reg(10, 8'hFF);
    wr_reg(7, 8'h80);
    @(negedge clk); addr = 4'd9;
    #1 chk("R12 page0 write ignored", 64'(rdata), 64'h00);
    check_all();

    // R11 ports 3..5 never interrupt, even with all enables on
    wr_reg(8, 8'hFF); wr_reg(9, 8'hFF); wr_reg(10, 8'hFF);
    set_ext(ext ^ 48'hFFFFFF_000000);
    set_ext(ext ^ 48'hFFFFFF_000000);
    chk("R11 high ports no pending", 64'(irq), 64'd0);
    check_all();

    // random traffic
    for (int i = 0; i < 220; i++) begin
      int op;
      op = int'($urandom % 5);
      case (op)
        0: wr_reg(int'($urandom % 6), 8'($urandom));
        1: wr_reg(7, {2'($urandom), ($urandom % 4 == 0) ? 6'($urandom) : 6'h00});
        2: wr_reg(8 + int'($urandom % 3), 8'($urandom));
        default: set_ext(ext ^ (48'({$urandom, $urandom}) & 48'({$urandom, $urandom})));
      endcase
      check_all();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule